// File: doc/BRIEF.md
# Link Interface Initialization Sequencer

This block sits on the physical-layer side of a link interface. It brings that interface out of a reset or disabled condition and back into normal service. It runs on a reference clock at twice the link clock rate. It watches a link power-status input and generates the gated link clock, including the pad enable for that clock. It also drives the two-bit control bus and the data bus, and every bit of both buses has its own output enable. Once the link layer may start issuing requests, it raises a ready flag.

A restart is honoured only after the interface has rested long enough. This rest is measured by a restore timer, which restarts on every reset, disable or drop of the power-status input. Next comes a wake delay, which is short for a normal restart and long when the physical layer is leaving a low-power state. The link clock then starts with a half-cycle low. This is followed by one cycle with both buses driven low, a quiet stretch up to the eighth link-clock cycle, a receive indication held for a set number of cycles, and finally the idle code. A mode input chooses between differentiated operation and direct operation. In differentiated operation the buses are released after the first cycle of each indication. In direct operation they remain driven.

Top module: `lnk_init_seq`

## Requirements
- R1: While reset is sampled high, and on the first sample after it, the phase is waiting, the link clock enable is 0, every control and data enable is 0, and the ready flag is 0.
- R2: A high power-status input has no effect until the restore timer runs out. The wake phase begins at the earliest on the (RESTORE_TICKS+1)-th edge after the last edge that saw reset, disable or a dropped power-status input. A short high pulse seen before that time never starts the sequence.
- R3: The wake phase lasts WAKE_FAST_TICKS reference ticks, or WAKE_LP_TICKS ticks when the low-power input is high on the edge that enters it. While in the wake phase, a clock that was stopped stays released.
- R4: The clock-start phase lasts exactly one tick, with the link clock low and enabled. After it the link clock alternates high then low, one tick each, for as long as the sequence runs.
- R5: Link-clock cycle 1 (two ticks) drives the control code 00 and all-zero data with every enable set.
- R6: Cycles 2 to 7 (twelve ticks) hold control and data at zero. The enables are all 1 when the mode input is 0 (direct) and all 0 when it is 1 (differentiated).
- R7: From cycle 8 the receive code 10 is placed on control and all ones on data for RX_CYCLES link-clock cycles. All enables are set during the first of these cycles.
- R8: During the later receive cycles the enables are 0 in differentiated mode and 1 in direct mode, and the values stay the same.
- R9: After the receive indication the block holds the idle code 00, zero data, all enables set and the ready flag at 1. The ready flag is 0 in every other phase.
- R10: If the power-status input drops while the sequence is under way, the next edge returns to waiting with all bus enables and the ready flag cleared. A link clock that was running keeps toggling, and the restore timer starts again.
- R11: A high disable input moves the block to waiting on the next edge with the link clock released. The restore timer is held at its start for as long as the input stays high.
- R12: The phase output encodes waiting as 0, wake as 1, clock start as 2, drive-low as 3, quiet cycles as 4, receive indication as 5 and ready as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the link clock rate |
| rst | input | 1 | Synchronous active-high reset |
| lps_i | input | 1 | Link power-status input |
| diff_mode_i | input | 1 | 1 selects differentiated (bus release) mode, 0 selects direct mode |
| low_power_i | input | 1 | Physical layer is in a low-power state, so the long wake delay applies |
| disable_i | input | 1 | Forces the disabled state with the link clock released |
| sclk_o | output | 1 | Generated link clock |
| sclk_oe_o | output | 1 | Output enable for the link clock pad |
| ctl_o | output | 2 | Control bus value |
| ctl_oe_o | output | 2 | Per-bit output enable for the control bus |
| d_o | output | D_WIDTH | Data bus value |
| d_oe_o | output | D_WIDTH | Per-bit output enable for the data bus |
| ready_o | output | 1 | The link layer may now issue requests |
| phase_o | output | 3 | Current sequence phase (encoding in R12) |

## Verification
The hardest cases are those where the restore timer is involved, and especially those where it is restarted by something other than reset. To reach them, the power-status input is dropped halfway through a sequence, and the disable input is held while the power-status input stays high. After each of these, the bench counts waiting samples to the exact edge. The per-bit release of the buses in differentiated mode is only visible in the quiet cycles and in the later receive cycles. For this reason every table row runs the whole sequence with the phase, the clock level and each enable group checked on every tick.

// File: rtl/lnk_init_pkg.sv
package lnk_init_pkg;

    typedef enum logic [2:0] {
        PH_WAIT  = 3'd0,
        PH_WAKE  = 3'd1,
        PH_START = 3'd2,
        PH_LOW   = 3'd3,
        PH_RUN   = 3'd4,
        PH_RX    = 3'd5,
        PH_READY = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        CTL_IDLE   = 2'b00,
        CTL_STATUS = 2'b01,
        CTL_RECV   = 2'b10,
        CTL_GRANT  = 2'b11
    } ctl_code_e;

    // Link-clock cycle numbers that mark sequence boundaries
    localparam int unsigned LOW_CYCLE  = 1;
    localparam int unsigned LAST_QUIET = 7;
    localparam int unsigned RX_CYCLE   = 8;
    localparam int unsigned CYC_W      = 4;

    typedef struct packed {
        ctl_code_e ctl;
        logic      ones;
        logic      oe;
    } bus_cmd_t;

    function automatic logic is_clocked(phase_e p);
        return (p == PH_LOW) || (p == PH_RUN) || (p == PH_RX) || (p == PH_READY);
    endfunction

    function automatic logic is_active(phase_e p);
        return (p != PH_WAIT);
    endfunction

    function automatic bus_cmd_t bus_cmd(phase_e p, logic diff, logic rx_first);
        bus_cmd_t c;
        c.ctl  = CTL_IDLE;
        c.ones = 1'b0;
        c.oe   = 1'b0;
        case (p)
            PH_LOW:   c.oe = 1'b1;
            PH_RUN:   c.oe = ~diff;
            PH_RX: begin
                c.ctl  = CTL_RECV;
                c.ones = 1'b1;
                c.oe   = rx_first | ~diff;
            end
            PH_READY: c.oe = 1'b1;
            default:  c.oe = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lnk_down_timer.sv
module lnk_down_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero_o = (cnt == '0);

    // Once expired, the timer stays expired until it is reloaded (R2, R3)
    p_zero_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load) |=> zero_o);

endmodule

// File: rtl/lnk_bus_drive.sv
module lnk_bus_drive
    import lnk_init_pkg::*;
#(
    parameter int unsigned D_WIDTH = 8
) (
    input  phase_e             phase_i,
    input  logic               diff_i,
    input  logic               rx_first_i,
    output logic [1:0]         ctl_o,
    output logic [1:0]         ctl_oe_o,
    output logic [D_WIDTH-1:0] d_o,
    output logic [D_WIDTH-1:0] d_oe_o
);
    bus_cmd_t cmd;

    always_comb cmd = bus_cmd(phase_i, diff_i, rx_first_i);

    assign ctl_o = cmd.ctl;

    for (genvar c = 0; c < 2; c++) begin : g_ctl_lane
        assign ctl_oe_o[c] = cmd.oe;
    end

    for (genvar i = 0; i < D_WIDTH; i++) begin : g_d_lane
        assign d_o[i]    = cmd.ones;
        assign d_oe_o[i] = cmd.oe;
    end

endmodule

// File: rtl/lnk_init_seq.sv
module lnk_init_seq
    import lnk_init_pkg::*;
#(
    parameter int unsigned D_WIDTH         = 8,
    parameter int unsigned RESTORE_TICKS   = 40,
    parameter int unsigned WAKE_FAST_TICKS = 5,
    parameter int unsigned WAKE_LP_TICKS   = 600000,
    parameter int unsigned RX_CYCLES       = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lps_i,
    input  logic               diff_mode_i,
    input  logic               low_power_i,
    input  logic               disable_i,
    output logic               sclk_o,
    output logic               sclk_oe_o,
    output logic [1:0]         ctl_o,
    output logic [1:0]         ctl_oe_o,
    output logic [D_WIDTH-1:0] d_o,
    output logic [D_WIDTH-1:0] d_oe_o,
    output logic               ready_o,
    output logic [2:0]         phase_o
);
    localparam int unsigned WAKE_MAX = (WAKE_LP_TICKS > WAKE_FAST_TICKS) ? WAKE_LP_TICKS
                                                                        : WAKE_FAST_TICKS;
    localparam int unsigned WCW = $clog2(WAKE_MAX + 1);
    localparam int unsigned RCW = $clog2(RESTORE_TICKS + 1);
    localparam int unsigned RXW = $clog2(RX_CYCLES + 1);

    phase_e           state;
    logic             hph;      // 0: high half of a link-clock cycle, 1: low half
    logic             clk_on;   // link clock was left running
    logic [CYC_W-1:0] cyc;
    logic [RXW-1:0]   rxcnt;

    logic restore_done, wake_done;
    logic restore_load, wake_load;
    logic lps_drop, go_wake;

    assign lps_drop = is_active(state) && !lps_i;
    assign go_wake  = (state == PH_WAIT) && restore_done && lps_i && !disable_i;

    assign restore_load = disable_i || lps_drop;
    assign wake_load    = go_wake;

    lnk_down_timer #(.CNT_W(RCW)) u_restore (
        .clk      (clk),
        .rst      (rst),
        .load     (restore_load),
        .load_val (RCW'(RESTORE_TICKS)),
        .zero_o   (restore_done)
    );

    lnk_down_timer #(.CNT_W(WCW)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .load     (wake_load),
        .load_val (low_power_i ? WCW'(WAKE_LP_TICKS - 1) : WCW'(WAKE_FAST_TICKS - 1)),
        .zero_o   (wake_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_WAIT;
            hph    <= 1'b0;
            clk_on <= 1'b0;
            cyc    <= '0;
            rxcnt  <= '0;
        end else if (disable_i) begin
            state  <= PH_WAIT;
            hph    <= 1'b0;
            clk_on <= 1'b0;
        end else if (lps_drop) begin
            state <= PH_WAIT;
            hph   <= ~hph;
        end else begin
            case (state)
                PH_WAIT: begin
                    hph <= ~hph;
                    if (go_wake) state <= PH_WAKE;
                end
                PH_WAKE: begin
                    hph <= ~hph;
                    if (wake_done) state <= PH_START;
                end
                PH_START: begin
                    state  <= PH_LOW;
                    hph    <= 1'b0;
                    clk_on <= 1'b1;
                    cyc    <= CYC_W'(LOW_CYCLE);
                end
                PH_LOW: begin
                    hph <= ~hph;
                    if (hph) begin
                        state <= PH_RUN;
                        cyc   <= cyc + 1'b1;
                    end
                end
                PH_RUN: begin
                    hph <= ~hph;
                    if (hph) begin
                        cyc <= cyc + 1'b1;
                        if (cyc == CYC_W'(LAST_QUIET)) begin
                            state <= PH_RX;
                            rxcnt <= RXW'(1);
                        end
                    end
                end
                PH_RX: begin
                    hph <= ~hph;
                    if (hph) begin
                        if (rxcnt == RXW'(RX_CYCLES)) state <= PH_READY;
                        else                          rxcnt <= rxcnt + 1'b1;
                    end
                end
                default: hph <= ~hph;   // PH_READY holds
            endcase
        end
    end

    assign sclk_o    = clk_on && (state != PH_START) && !hph;
    assign sclk_oe_o = clk_on || (state == PH_START);
    assign ready_o   = (state == PH_READY);
    assign phase_o   = state;

    lnk_bus_drive #(.D_WIDTH(D_WIDTH)) u_bus (
        .phase_i    (state),
        .diff_i     (diff_mode_i),
        .rx_first_i (rxcnt == RXW'(1)),
        .ctl_o      (ctl_o),
        .ctl_oe_o   (ctl_oe_o),
        .d_o        (d_o),
        .d_oe_o     (d_oe_o)
    );

    // Leaving the waiting phase only happens once the restore timer has expired
    p_wake_after_restore_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_WAKE && $past(state) == PH_WAIT) |-> $past(restore_done));

    // The half-cycle low start is a single tick
    p_start_one_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (state == PH_START) |=> (state == PH_LOW || state == PH_WAIT));

    // Inside the running sequence the link clock changes level on every tick
    p_sclk_toggles_r4: assert property (@(posedge clk) disable iff (rst)
        (is_clocked(state) && is_clocked($past(state))) |-> (sclk_o != $past(sclk_o)));

    // The receive indication begins on link-clock cycle eight, straight from the quiet cycles
    p_rx_on_cycle8_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RX && $past(state) != PH_RX)
            |-> ($past(state) == PH_RUN && cyc == CYC_W'(RX_CYCLE)));

    // Ready means idle code and zero data on fully driven buses
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (ctl_o == CTL_IDLE && d_o == '0 && (&d_oe_o) && (&ctl_oe_o)));

    // A dropped power-status input aborts the sequence on the next edge
    p_lps_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (is_active(state) && !lps_i) |=> (state == PH_WAIT && !ready_o && d_oe_o == '0));

    // Disable releases the link clock on the next edge
    p_disable_release_r11: assert property (@(posedge clk) disable iff (rst)
        disable_i |=> (!sclk_oe_o && state == PH_WAIT));

endmodule

// File: tb/tb_lnk_init_seq.sv
module tb_lnk_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int REST = 10;
    localparam int FAST = 3;
    localparam int LP   = 40;
    localparam int RXC  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lps = 1'b0, diff = 1'b0, lowp = 1'b0, dis = 1'b0;
    logic sclk, sclk_oe, ready;
    logic [1:0] ctl, ctl_oe;
    logic [DW-1:0] d, d_oe;
    logic [2:0] phase;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_init_seq #(
        .D_WIDTH(DW), .RESTORE_TICKS(REST), .WAKE_FAST_TICKS(FAST),
        .WAKE_LP_TICKS(LP), .RX_CYCLES(RXC)
    ) dut (
        .clk(clk), .rst(rst), .lps_i(lps), .diff_mode_i(diff),
        .low_power_i(lowp), .disable_i(dis),
        .sclk_o(sclk), .sclk_oe_o(sclk_oe), .ctl_o(ctl), .ctl_oe_o(ctl_oe),
        .d_o(d), .d_oe_o(d_oe), .ready_o(ready), .phase_o(phase)
    );

    typedef struct packed {
        logic diff;
        logic lp;
        int   exp_wake;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{diff: 1'b0, lp: 1'b0, exp_wake: FAST},
        '{diff: 1'b1, lp: 1'b0, exp_wake: FAST},
        '{diff: 1'b0, lp: 1'b1, exp_wake: LP},
        '{diff: 1'b1, lp: 1'b1, exp_wake: LP}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_until(input int ph, input int limit);
        for (int k = 0; k < limit && phase != 3'(ph); k++) tick();
    endtask

    task automatic run_seq(input logic dm, input logic lpm, input int exp_w);
        int pc [8];
        bit bad4 = 0, bad5 = 0, bad6 = 0, bad7 = 0, bad8 = 0, bad9 = 0;
        int clk_k = 0, rx_k = 0, rdy = 0;
        logic [DW-1:0] full_oe;
        full_oe = '1;
        foreach (pc[i]) pc[i] = 0;
        diff = dm;
        lowp = lpm;
        lps  = 1'b1;
        for (int n = 0; n < 400 && rdy < 4; n++) begin
            tick();
            pc[phase]++;
            if (phase != 3'd6 && ready !== 1'b0) bad9 = 1;
            if (phase == 3'd2 && (sclk !== 1'b0 || sclk_oe !== 1'b1)) bad4 = 1;
            if (phase >= 3'd3 && phase <= 3'd6) begin
                if (sclk !== ((clk_k % 2) == 0) || sclk_oe !== 1'b1) bad4 = 1;
                clk_k++;
            end
            case (phase)
                3'd3: if (ctl !== 2'b00 || d !== '0 || ctl_oe !== 2'b11 || d_oe !== full_oe) bad5 = 1;
                3'd4: if (ctl !== 2'b00 || d !== '0 ||
                          ctl_oe !== (dm ? 2'b00 : 2'b11) || d_oe !== (dm ? '0 : full_oe)) bad6 = 1;
                3'd5: begin
                    if (rx_k < 2) begin
                        if (ctl !== 2'b10 || d !== full_oe || ctl_oe !== 2'b11 || d_oe !== full_oe) bad7 = 1;
                    end else begin
                        if (ctl !== 2'b10 || d !== full_oe ||
                            ctl_oe !== (dm ? 2'b00 : 2'b11) || d_oe !== (dm ? '0 : full_oe)) bad8 = 1;
                    end
                    rx_k++;
                end
                3'd6: begin
                    rdy++;
                    if (ctl !== 2'b00 || d !== '0 || ctl_oe !== 2'b11 || d_oe !== full_oe || ready !== 1'b1) bad9 = 1;
                end
                default: ;
            endcase
        end
        chk(pc[1] == exp_w, "R3 wake ticks", pc[1], exp_w);
        chk(pc[2] == 1, "R4 start ticks", pc[2], 1);
        chk(!bad4, "R4 clock waveform", bad4, 0);
        chk(pc[3] == 2 && !bad5, "R5 drive-low cycle", pc[3], 2);
        chk(pc[4] == 12 && !bad6, "R6 quiet cycles", pc[4], 12);
        chk(pc[5] == 2*RXC && !bad7, "R7 receive indication", pc[5], 2*RXC);
        chk(!bad8, "R8 later receive cycles", bad8, 0);
        chk(pc[6] == 4 && !bad9, "R9 ready idle", pc[6], 4);
        chk(pc[0] == 0 && pc[7] == 0, "R12 phase codes", pc[7], 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        int cnt;
        bit bad;
        logic s0;

        // R1 reset state
        @(negedge clk);
        tick(); tick();
        chk(phase == 3'd0 && sclk_oe == 1'b0 && ctl_oe == '0 && d_oe == '0 && ready == 1'b0,
            "R1 reset state", phase, 0);
        rst = 1'b0;
        tick();
        chk(phase == 3'd0 && sclk_oe == 1'b0 && ready == 1'b0, "R1 after release", phase, 0);

        // R2 early pulse ignored
        lps = 1'b1; tick(); tick();
        lps = 1'b0;
        bad = 0;
        for (int k = 0; k < REST + 10; k++) begin
            tick();
            if (phase != 3'd0 || sclk_oe != 1'b0) bad = 1;
        end
        chk(!bad, "R2 early pulse ignored", phase, 0);

        // Table of stimulus and expected results
        foreach (VECS[v]) begin
            run_seq(VECS[v].diff, VECS[v].lp, VECS[v].exp_wake);
            lps = 1'b0;
            tick();
            chk(phase == 3'd0 && sclk_oe == 1'b1 && d_oe == '0 && ctl_oe == '0 && ready == 1'b0,
                "R10 drop from ready", phase, 0);
            for (int k = 0; k < REST + 3; k++) tick();
        end

        // R2 exact restore count after reset with power-status held high
        diff = 1'b0; lowp = 1'b0;
        rst = 1'b1; lps = 1'b1;
        tick(); tick();
        rst = 1'b0;
        cnt = 0;
        for (int k = 0; k < 100 && phase == 3'd0; k++) begin
            tick();
            if (phase == 3'd0) cnt++;
        end
        chk(cnt == REST, "R2 restore after reset", cnt, REST);

        // R10 drop during quiet cycles, clock keeps running, restore restarts
        tick_until(4, 200);
        lps = 1'b0;
        tick();
        chk(phase == 3'd0 && sclk_oe == 1'b1 && d_oe == '0, "R10 drop mid sequence", phase, 0);
        s0 = sclk;
        tick();
        chk(sclk != s0 && sclk_oe == 1'b1, "R10 clock keeps running", sclk, !s0);
        lps = 1'b1;
        cnt = 2;
        for (int k = 0; k < 100 && phase == 3'd0; k++) begin
            tick();
            if (phase == 3'd0) cnt++;
        end
        chk(cnt == REST + 1, "R10 restore restarted by drop", cnt, REST + 1);

        // R11 disable from ready
        tick_until(6, 200);
        chk(ready == 1'b1, "R9 ready reached", ready, 1);
        dis = 1'b1;
        tick();
        chk(phase == 3'd0 && sclk_oe == 1'b0 && ready == 1'b0, "R11 disable releases clock", sclk_oe, 0);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            tick();
            if (phase != 3'd0 || sclk_oe != 1'b0) bad = 1;
        end
        chk(!bad, "R11 held while disabled", phase, 0);
        dis = 1'b0;
        cnt = 0;
        for (int k = 0; k < 100 && phase == 3'd0; k++) begin
            tick();
            if (phase == 3'd0) cnt++;
        end
        chk(cnt == REST, "R11 restore timer held during disable", cnt, REST);
        chk(phase == 3'd1 && sclk_oe == 1'b0, "R3 clock stays released in wake", sclk_oe, 0);
        tick_until(2, 100);
        chk(phase == 3'd2 && sclk_oe == 1'b1 && sclk == 1'b0, "R4 restart after disable", sclk_oe, 1);
        tick_until(6, 100);
        chk(ready == 1'b1 && ctl == 2'b00, "R9 ready after disable cycle", ready, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule